// File: doc/BRIEF.md
# Low-Power DRAM Power-State Tracker

This block follows the power state of a low-power mobile DRAM device from the controller side. Each cycle it takes the clock-enable level, the chip-select level and a command that has already been decoded, with its bank number. From the activate and precharge commands it keeps its own record of which banks are open. From the record and the commands it knows whether the device is active, idle, or in one of four low-power states. Entry into a low-power state is decided in the one cycle where clock enable first drops. If a bank is open, the device freezes in active power-down. Otherwise the command in that cycle selects the state: a no-operation gives idle power-down, a refresh gives self-refresh, and a burst terminate gives deep power-down.

The block also keeps the round-robin pointer that names the bank the next per-bank refresh will act on. A single-cycle error flag reports commands that are not allowed. These are non-NOP commands while powered down, a disallowed entry command, a per-bank refresh in reduced-bank mode, and an attempt to leave deep power-down by raising clock enable. Deep power-down is left only through reset. A configuration input selects between the full bank count and a reduced mode that uses half the banks. In reduced mode the top bank-address bit is ignored.

Top module: `lpdram_pwr_tracker`

## Requirements
- R1: While reset is asserted, and until the first command after it, the state output is IDLE (code 1), all banks are closed, the refresh bank output is 0 and the error flag is low.
- R2: Command codes on `cmd_i` are: NOP=0, ACT=1, RD=2, WR=3, PRE=4, PREA=5, BST=6, REFAB=7, REFPB=8, MRR=9, MRW=10. A command with `cs_ni` high counts as NOP.
- R3: While powered up with CKE high, an ACT marks its bank open, a PRE closes its bank, and a PREA closes all banks. The state output registered after the command is ACTIVE (code 0) if any bank is open and IDLE (code 1) otherwise. In reduced mode (`full_banks_i`=0) bank bit 2 is ignored.
- R4: On a cycle where CKE falls (high on the previous edge, low now) with a bank open, the state becomes ACT_PD (code 2) whatever the command. The banks stay open, and a later CKE rise returns the state to ACTIVE.
- R5: On a CKE fall with no bank open and an effective NOP, the state becomes IDLE_PD (code 3). A CKE rise returns it to IDLE.
- R6: On a CKE fall with no bank open and REFAB or REFPB, the state becomes SELF_REF (code 4). A CKE rise returns it to IDLE.
- R7: On a CKE fall with no bank open and BST, the state becomes DEEP_PD (code 5). A CKE rise leaves it in DEEP_PD and sets the error flag. Only reset leaves DEEP_PD.
- R8: In full mode each executed REFPB advances the refresh bank output by one, wrapping from 7 to 0. A command issued on a CKE fall is not executed and does not advance the pointer.
- R9: In reduced mode a REFPB sets the error flag and leaves the refresh bank output unchanged.
- R10: Any effective command other than NOP while in a power-down state, including on the cycle CKE rises, sets the error flag. The command is ignored: bank state and refresh pointer do not change.
- R11: On a CKE fall with no bank open and a command other than NOP, REFAB, REFPB or BST, the state becomes IDLE_PD and the error flag is set.
- R12: The error flag is registered. It is high for exactly the cycle after the offending edge and low again once no new fault occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cke_i | input | 1 | Device clock-enable level |
| cs_ni | input | 1 | Active-low chip select; high forces NOP |
| cmd_i | input | 4 | Decoded command code (see R2) |
| bank_i | input | 3 | Bank address of the command |
| full_banks_i | input | 1 | 1: eight banks, 0: four banks |
| pwr_state_o | output | 3 | Power state code (see R3 to R7) |
| ref_bank_o | output | 3 | Bank for the next per-bank refresh |
| err_o | output | 1 | One-cycle flag for an illegal command or exit |

## Verification
The cases that matter most are those where a clock-enable edge and a command fall in the same cycle. On a clock-enable fall, the command picks the low-power state rather than being executed. The bench provokes this by issuing a per-bank refresh, an activate, a read or a burst terminate on the falling cycle. It then judges that the state changes, the refresh pointer stays put, and no bank opens. On a clock-enable rise, the bench pairs the rise with an activate. It expects a return to idle together with the error flag, and the banks must stay closed. A behavioural model in the bench is compared with the outputs on every clock.

// File: rtl/lpdram_pwr_pkg.sv
package lpdram_pwr_pkg;

  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_ACT   = 4'd1,
    CMD_RD    = 4'd2,
    CMD_WR    = 4'd3,
    CMD_PRE   = 4'd4,
    CMD_PREA  = 4'd5,
    CMD_BST   = 4'd6,
    CMD_REFAB = 4'd7,
    CMD_REFPB = 4'd8,
    CMD_MRR   = 4'd9,
    CMD_MRW   = 4'd10
  } cmd_e;

  typedef enum logic [2:0] {
    PS_ACTIVE   = 3'd0,
    PS_IDLE     = 3'd1,
    PS_ACT_PD   = 3'd2,
    PS_IDLE_PD  = 3'd3,
    PS_SELF_REF = 3'd4,
    PS_DEEP_PD  = 3'd5
  } pstate_e;

endpackage

// File: rtl/lpdram_cke_edge.sv
module lpdram_cke_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cke_i,
  output logic fall_o,
  output logic rise_o
);
  logic cke_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cke_q <= 1'b1;
    else         cke_q <= cke_i;
  end

  assign fall_o = cke_q & ~cke_i;
  assign rise_o = ~cke_q & cke_i;

endmodule

// File: rtl/lpdram_bank_track.sv
module lpdram_bank_track
  import lpdram_pwr_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  cmd_e              cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              full_banks_i,
  output logic              any_open_o,
  output logic              next_any_open_o
);
  logic [NUM_BANKS-1:0] open_q, open_d;
  logic [BANK_W-1:0]    idx;

  // reduced mode drops the top bank-address bit
  assign idx = full_banks_i ? bank_i : {1'b0, bank_i[BANK_W-2:0]};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (idx == BANK_W'(b));
    always_comb begin
      open_d[b] = open_q[b];
      if (exec_i) begin
        if (cmd_i == CMD_ACT && hit)                        open_d[b] = 1'b1;
        else if ((cmd_i == CMD_PRE && hit) || cmd_i == CMD_PREA) open_d[b] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) open_q <= '0;
    else         open_q <= open_d;
  end

  assign any_open_o      = |open_q;
  assign next_any_open_o = |open_d;

  // R10: banks are frozen whenever commands are not executed
  a_r10_banks_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> $stable(open_q));

endmodule

// File: rtl/lpdram_ref_ptr.sv
module lpdram_ref_ptr
  import lpdram_pwr_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_i,
  input  cmd_e              cmd_i,
  input  logic              full_banks_i,
  output logic [BANK_W-1:0] ptr_o,
  output logic              bad_o
);
  localparam logic [BANK_W-1:0] LAST = BANK_W'(NUM_BANKS - 1);

  logic [BANK_W-1:0] ptr_q, ptr_d;
  logic              is_refpb, step;

  assign is_refpb = exec_i && (cmd_i == CMD_REFPB);
  assign step     = is_refpb && full_banks_i;
  assign bad_o    = is_refpb && !full_banks_i;

  always_comb begin
    ptr_d = ptr_q;
    if (step) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;

  // R8: one step per executed per-bank refresh, wrapping at the last bank
  a_r8_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && cmd_i == CMD_REFPB && full_banks_i) |=>
      (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1)));

  // R9: no movement unless a full-mode per-bank refresh is executed
  a_r9_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(exec_i && cmd_i == CMD_REFPB && full_banks_i) |=> $stable(ptr_q));

endmodule

// File: rtl/lpdram_pwr_fsm.sv
module lpdram_pwr_fsm
  import lpdram_pwr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    cke_i,
  input  logic    fall_i,
  input  logic    rise_i,
  input  cmd_e    cmd_i,
  input  logic    any_open_i,
  input  logic    next_any_open_i,
  input  logic    ref_bad_i,
  output logic    exec_o,
  output pstate_e state_o,
  output logic    err_o
);
  pstate_e state_q, state_d;
  logic    err_q, err_d;
  logic    powered_up;

  assign powered_up = (state_q == PS_ACTIVE) || (state_q == PS_IDLE);
  assign exec_o     = powered_up && cke_i;

  always_comb begin
    state_d = state_q;
    err_d   = 1'b0;
    unique case (state_q)
      PS_ACTIVE, PS_IDLE: begin
        if (fall_i) begin
          if (any_open_i) state_d = PS_ACT_PD;
          else begin
            unique case (cmd_i)
              CMD_NOP:              state_d = PS_IDLE_PD;
              CMD_REFAB, CMD_REFPB: state_d = PS_SELF_REF;
              CMD_BST:              state_d = PS_DEEP_PD;
              default: begin
                state_d = PS_IDLE_PD;
                err_d   = 1'b1;
              end
            endcase
          end
        end else if (cke_i) begin
          state_d = next_any_open_i ? PS_ACTIVE : PS_IDLE;
          err_d   = ref_bad_i;
        end
      end
      PS_ACT_PD: begin
        err_d = (cmd_i != CMD_NOP);
        if (rise_i) state_d = PS_ACTIVE;
      end
      PS_IDLE_PD, PS_SELF_REF: begin
        err_d = (cmd_i != CMD_NOP);
        if (rise_i) state_d = PS_IDLE;
      end
      PS_DEEP_PD: begin
        err_d = (cmd_i != CMD_NOP) || rise_i;
      end
      default: state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  assign state_o = state_q;
  assign err_o   = err_q;

  // R7: deep power-down is never left without reset
  a_r7_deep_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_DEEP_PD) |=> (state_q == PS_DEEP_PD));

  // R5: idle power-down only stays or returns to idle
  a_r5_idle_pd_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_IDLE_PD) |=> (state_q == PS_IDLE_PD || state_q == PS_IDLE));

  // R4: active power-down only stays or returns to active
  a_r4_act_pd_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_ACT_PD) |=> (state_q == PS_ACT_PD || state_q == PS_ACTIVE));

  // R6: self-refresh only stays or returns to idle
  a_r6_sref_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_SELF_REF) |=> (state_q == PS_SELF_REF || state_q == PS_IDLE));

endmodule

// File: rtl/lpdram_pwr_tracker.sv
module lpdram_pwr_tracker
  import lpdram_pwr_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              cs_ni,
  input  logic [3:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              full_banks_i,
  output logic [2:0]        pwr_state_o,
  output logic [BANK_W-1:0] ref_bank_o,
  output logic              err_o
);
  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  cmd_e    cmd_eff;
  logic    fall, rise, exec, any_open, next_any_open, ref_bad;
  pstate_e state;

  assign cmd_eff = cs_ni ? CMD_NOP : cmd_e'(cmd_i);

  lpdram_cke_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .cke_i  (cke_i),
    .fall_o (fall),
    .rise_o (rise)
  );

  lpdram_bank_track #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_banks (
    .clk_i           (clk_i),
    .rst_ni          (rst_n_int),
    .exec_i          (exec),
    .cmd_i           (cmd_eff),
    .bank_i          (bank_i),
    .full_banks_i    (full_banks_i),
    .any_open_o      (any_open),
    .next_any_open_o (next_any_open)
  );

  lpdram_ref_ptr #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_ref (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_int),
    .exec_i       (exec),
    .cmd_i        (cmd_eff),
    .full_banks_i (full_banks_i),
    .ptr_o        (ref_bank_o),
    .bad_o        (ref_bad)
  );

  lpdram_pwr_fsm u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_n_int),
    .cke_i           (cke_i),
    .fall_i          (fall),
    .rise_i          (rise),
    .cmd_i           (cmd_eff),
    .any_open_i      (any_open),
    .next_any_open_i (next_any_open),
    .ref_bad_i       (ref_bad),
    .exec_o          (exec),
    .state_o         (state),
    .err_o           (err_o)
  );

  assign pwr_state_o = state;

  // R10: a powered-down state never changes the refresh pointer
  a_r10_pd_ptr_frozen: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (state != PS_ACTIVE && state != PS_IDLE) |=> $stable(ref_bank_o));

endmodule

// File: tb/lpdram_pwr_tracker_test.sv
module lpdram_pwr_tracker_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke = 1'b1, cs_n = 1'b0, full = 1'b1;
  logic [3:0] cmd = 4'd0;
  logic [2:0] bank = 3'd0;
  logic [2:0] st;
  logic [2:0] rb;
  logic       err;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  lpdram_pwr_tracker uut (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .cmd_i(cmd),
    .bank_i(bank), .full_banks_i(full), .pwr_state_o(st),
    .ref_bank_o(rb), .err_o(err)
  );

  // behavioural reference model
  int m_state, m_ptr;
  bit m_open[8];
  bit m_err, m_cke;

  function automatic bit any_open();
    foreach (m_open[i]) if (m_open[i]) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 1; m_ptr = 0; m_err = 0; m_cke = 1;
      foreach (m_open[i]) m_open[i] = 0;
    end else begin
      int  e, b;
      bit  fl, rs, ne;
      e  = cs_n ? 0 : int'(cmd);
      fl = m_cke && !cke;
      rs = !m_cke && cke;
      ne = 0;
      if (m_state == 0 || m_state == 1) begin
        if (fl) begin
          if (any_open()) m_state = 2;
          else if (e == 0) m_state = 3;
          else if (e == 7 || e == 8) m_state = 4;
          else if (e == 6) m_state = 5;
          else begin m_state = 3; ne = 1; end
        end else if (cke) begin
          b = full ? int'(bank) : int'(bank) % 4;
          if (e == 1) m_open[b] = 1;
          else if (e == 4) m_open[b] = 0;
          else if (e == 5) foreach (m_open[i]) m_open[i] = 0;
          else if (e == 8) begin
            if (full) m_ptr = (m_ptr + 1) % 8;
            else ne = 1;
          end
          m_state = any_open() ? 0 : 1;
        end
      end else begin
        if (e != 0) ne = 1;
        if (m_state == 5) begin
          if (rs) ne = 1;
        end else if (rs) m_state = (m_state == 2) ? 0 : 1;
      end
      m_cke = cke;
      m_err = ne;
    end
  end

  task automatic chk(int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(int'(st), m_state, "model state");
      chk(int'(rb), m_ptr, "model refresh bank");
      chk(int'(err), int'(m_err), "model error");
    end
  end

  task automatic tick(bit k, bit c, int op, int bk);
    cke = k; cs_n = c; cmd = 4'(op); bank = 3'(bk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1, 0, 0, 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      summary();
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    chk(int'(st), 1, "R1 reset state");
    chk(int'(rb), 0, "R1 reset pointer");
    chk(int'(err), 0, "R1 reset error");
    rst_n = 1'b1;
    idle(4);
    chk(int'(st), 1, "R1 idle after release");

    cur_req = "R3";
    tick(1, 0, 1, 2);
    chk(int'(st), 0, "R3 activate gives ACTIVE");
    tick(1, 0, 4, 2);
    chk(int'(st), 1, "R3 precharge gives IDLE");
    tick(1, 0, 1, 5); tick(1, 0, 1, 1); tick(1, 0, 10, 0);
    chk(int'(st), 0, "R3 mode write leaves banks");
    tick(1, 0, 5, 0);
    chk(int'(st), 1, "R3 precharge all");
    full = 1'b0;
    tick(1, 0, 1, 6); tick(1, 0, 4, 2);
    chk(int'(st), 1, "R3 reduced mode drops bit 2");
    full = 1'b1;

    cur_req = "R8";
    for (int i = 0; i < 9; i++) tick(1, 0, 8, 0);
    chk(int'(rb), 1, "R8 pointer wraps after 9 refreshes");

    cur_req = "R9";
    full = 1'b0;
    tick(1, 0, 8, 0);
    chk(int'(err), 1, "R9 reduced-mode refresh error");
    chk(int'(rb), 1, "R9 pointer held");
    cur_req = "R12";
    tick(1, 0, 0, 0);
    chk(int'(err), 0, "R12 error clears");
    full = 1'b1;

    cur_req = "R4";
    tick(1, 0, 1, 3);
    tick(0, 0, 6, 0);
    chk(int'(st), 2, "R4 open bank overrides BST");
    tick(0, 0, 0, 0);
    chk(int'(st), 2, "R4 held");
    tick(1, 0, 0, 0);
    chk(int'(st), 0, "R4 returns ACTIVE");
    tick(1, 0, 4, 3);
    chk(int'(st), 1, "R4 bank closed afterwards");

    cur_req = "R5";
    tick(0, 1, 1, 4);
    chk(int'(st), 3, "R5 chip-select high as NOP");
    tick(1, 0, 0, 0);
    chk(int'(st), 1, "R5 returns IDLE");

    cur_req = "R10";
    tick(0, 0, 0, 0);
    tick(0, 0, 1, 4);
    chk(int'(err), 1, "R10 command while down");
    tick(0, 0, 8, 0);
    chk(int'(rb), 1, "R10 pointer untouched");
    tick(1, 0, 1, 2);
    chk(int'(st), 1, "R10 rise with ACT not executed");
    chk(int'(err), 1, "R10 rise with ACT flagged");
    tick(1, 0, 0, 0);
    chk(int'(st), 1, "R10 no bank opened");

    cur_req = "R6";
    tick(0, 0, 8, 0);
    chk(int'(st), 4, "R6 per-bank refresh enters self-refresh");
    chk(int'(rb), 1, "R8 entry command not executed");
    tick(0, 0, 0, 0); tick(1, 0, 0, 0);
    chk(int'(st), 1, "R6 self-refresh exits to IDLE");
    tick(0, 0, 7, 0);
    chk(int'(st), 4, "R6 all-bank refresh entry");
    tick(1, 0, 0, 0);

    cur_req = "R11";
    tick(0, 0, 2, 0);
    chk(int'(st), 3, "R11 read at fall gives IDLE_PD");
    chk(int'(err), 1, "R11 read at fall flagged");
    tick(1, 0, 0, 0);

    cur_req = "R7";
    tick(0, 0, 6, 0);
    chk(int'(st), 5, "R7 BST enters deep power-down");
    tick(1, 0, 0, 0);
    chk(int'(st), 5, "R7 CKE rise does not exit");
    chk(int'(err), 1, "R7 illegal exit flagged");
    tick(1, 0, 1, 0);
    chk(int'(st), 5, "R7 still deep");
    tick(1, 0, 0, 0);
    chk(int'(err), 0, "R12 flag drops");
    rst_n = 1'b0;
    tick(1, 0, 0, 0);
    cur_req = "R1";
    chk(int'(st), 1, "R1 reset leaves deep power-down");
    chk(int'(rb), 0, "R1 pointer cleared");
    rst_n = 1'b1;
    idle(4);
    cur_req = "R2";
    tick(1, 1, 1, 0);
    chk(int'(st), 1, "R2 chip-select high ignores ACT");
    idle(2);

    summary();
    $finish;
  end

endmodule